// File: doc/BRIEF.md
# Region access permission checker

This block sits beside one bus master and decides, in the same cycle, whether that master's access may proceed. The decision rests on a small set of programmable address windows. Each window has an inclusive lower and upper bound, an enable bit, and separate read, write and execute rights for each of three privilege modes. A lock bit freezes a window's settings until reset.

When an access is refused, the block sorts the fault into one of two kinds: the address falls in no enabled window, or it falls in at least one window but none of those grants the right. It sets a sticky status bit for that kind. On the first fault after the status was clear, it also stores the address, mode, master ID and the set of windows that matched. A status-clear strobe rearms the capture. An interrupt line reports pending faults when software has enabled it. A plain 32-bit write/read register port holds all configuration. Reads are combinational on the address, and writes take effect at the clock edge.

Top module: `region_guard`

## Requirements
- R1: After reset these reads hold: window enable (0x00) = 1, window 0 lower bound (0x04) = 0, upper bound (0x08) = 0xFFFFFFFF, attributes (0x0C) = 0, check enable (0xC4) = 1, status (0xC8) = 0, interrupt enable (0xD8) = 0, clock-keep (0xDC) = 1, and `irq` = 0.
- R2: Window n occupies 0x04+12n (lower), 0x08+12n (upper) and 0x0C+12n (attributes), and bit n of 0x00 enables it. A window matches when it is enabled and lower ≤ address ≤ upper, with both bounds included. An address that no enabled window matches is refused while checking is on.
- R3: In the attribute word, mode m uses bits [4m+2:4m]: execute at 4m, write at 4m+1, read at 4m+2. Access type is encoded 0 = read, 1 = write, 2 = execute. An access is allowed when any matching window grants the requested right to the requested mode. Mode 3 and type 3 are always refused.
- R4: With bit 0 of 0xC4 cleared, every access is allowed and the status stays 0.
- R5: A refused access with `acc_valid` high sets status (0xC8) bit 1 if no window matched, and bit 0 otherwise. It is visible from the next cycle. The bits are sticky and accumulate over later faults.
- R6: Writing a value with bit 0 set to 0xCC clears the status. Register 0xCC always reads 0.
- R7: Fault details are captured only when the status is 0 (or is being cleared in the same cycle). Info word 0 (0xD0) holds the matched-window bitmap in [3:0] (0 for a no-match fault), the mode in [17:16] and the master ID in [22:18]. Info word 1 (0xD4) holds the address. Both stay held until the next capture.
- R8: `irq` is high exactly when the status is nonzero and bit 0 of 0xD8 is set.
- R9: Attribute bit 11 locks a window. Writes to that window's lower, upper and attribute registers are then ignored until reset, including writes that clear the lock. The enable bits in 0x00 stay writable.
- R10: Attribute bits 3 and 7 and bits [31:12] read 0. 0x7FC reads the constant `VERSION`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_mode | input | 2 | Privilege mode |
| acc_id | input | ID_W | Master ID |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| acc_allow | output | 1 | Access permitted (combinational) |
| irq | output | 1 | Fault interrupt |

## Verification
The bench builds the block with its defaults: four windows, 32-bit addresses and 5-bit IDs. This allows two windows that overlap, so one address can be granted by either of them. It also leaves the upper windows free to test reserved-bit masking and the lock. The walk covers both bounds of each window and the addresses just outside them. It also covers every right, every mode including the invalid one, and a fault that only the second window could have granted.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W = 32,
  parameter int ID_W = 5,
  parameter logic [31:0] VERSION = 32'h0240_1106
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_mode,
  input  logic [ID_W-1:0]   acc_id,
  input  logic [1:0]        acc_type,
  output logic              acc_allow,
  output logic              irq
);
  localparam logic [11:0] A_EN   = 12'h000;
  localparam logic [11:0] A_FUNC = 12'h0C4;
  localparam logic [11:0] A_STAT = 12'h0C8;
  localparam logic [11:0] A_CLR  = 12'h0CC;
  localparam logic [11:0] A_INF0 = 12'h0D0;
  localparam logic [11:0] A_INF1 = 12'h0D4;
  localparam logic [11:0] A_IEN  = 12'h0D8;
  localparam logic [11:0] A_CKG  = 12'h0DC;
  localparam logic [11:0] A_VER  = 12'h7FC;
  localparam logic [11:0] ATTR_MASK = 12'hF77;

  logic [NUM_REGIONS-1:0] win_en;
  logic func_en, int_en, clk_keep;
  logic [1:0] status;
  logic [NUM_REGIONS-1:0] info_region;
  logic [1:0] info_mode;
  logic [ID_W-1:0] info_id;
  logic [ADDR_W-1:0] info_addr;

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] lo_w, hi_w;
  logic [NUM_REGIONS-1:0][11:0] attr_w;
  logic [NUM_REGIONS-1:0] match, grant;

  logic [3:0] right_sel;
  logic       req_ok;
  assign right_sel = {acc_mode, 2'b00} + ((acc_type == 2'd0) ? 4'd2 : (acc_type == 2'd1) ? 4'd1 : 4'd0);
  assign req_ok = (acc_mode != 2'd3) && (acc_type != 2'd3);

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : gen_win
      localparam logic [11:0] OFS = 12'(4 + 12 * g);
      logic [ADDR_W-1:0] lo, hi;
      logic [11:0] attr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo   <= '0;
          hi   <= '1;
          attr <= '0;
        end else if (reg_we && !attr[11]) begin
          if (reg_addr == OFS)         lo   <= reg_wdata[ADDR_W-1:0];
          if (reg_addr == OFS + 12'd4) hi   <= reg_wdata[ADDR_W-1:0];
          if (reg_addr == OFS + 12'd8) attr <= reg_wdata[11:0] & ATTR_MASK;
        end
      end
      assign lo_w[g]   = lo;
      assign hi_w[g]   = hi;
      assign attr_w[g] = attr;
      assign match[g]  = win_en[g] && (acc_addr >= lo) && (acc_addr <= hi);
      assign grant[g]  = match[g] && req_ok && attr[right_sel];
    end
  endgenerate

  logic hit, viol, clr;
  logic [1:0] kind;
  assign hit       = |match;
  assign acc_allow = !func_en || (|grant);
  assign viol      = acc_valid && !acc_allow;
  assign kind      = hit ? 2'b01 : 2'b10;
  assign clr       = reg_we && (reg_addr == A_CLR) && reg_wdata[0];
  assign irq       = int_en && (|status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en   <= NUM_REGIONS'(1);
      func_en  <= 1'b1;
      int_en   <= 1'b0;
      clk_keep <= 1'b1;
    end else if (reg_we) begin
      if (reg_addr == A_EN)   win_en   <= reg_wdata[NUM_REGIONS-1:0];
      if (reg_addr == A_FUNC) func_en  <= reg_wdata[0];
      if (reg_addr == A_IEN)  int_en   <= reg_wdata[0];
      if (reg_addr == A_CKG)  clk_keep <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status      <= '0;
      info_region <= '0;
      info_mode   <= '0;
      info_id     <= '0;
      info_addr   <= '0;
    end else if (viol) begin
      status <= (clr ? 2'b00 : status) | kind;
      if (clr || status == 2'b00) begin
        info_region <= match;
        info_mode   <= acc_mode;
        info_id     <= acc_id;
        info_addr   <= acc_addr;
      end
    end else if (clr) begin
      status <= '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:   reg_rdata = 32'(win_en);
      A_FUNC: reg_rdata = {31'd0, func_en};
      A_STAT: reg_rdata = {30'd0, status};
      A_INF0: reg_rdata = {9'd0, 5'(info_id), info_mode, 12'd0, 4'(info_region)};
      A_INF1: reg_rdata = 32'(info_addr);
      A_IEN:  reg_rdata = {31'd0, int_en};
      A_CKG:  reg_rdata = {31'd0, clk_keep};
      A_VER:  reg_rdata = VERSION;
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (reg_addr == 12'(4 + 12 * i))  reg_rdata = 32'(lo_w[i]);
      if (reg_addr == 12'(8 + 12 * i))  reg_rdata = 32'(hi_w[i]);
      if (reg_addr == 12'(12 + 12 * i)) reg_rdata = {20'd0, attr_w[i]};
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              func_en,
  input logic              hit,
  input logic              acc_valid,
  input logic              acc_allow,
  input logic [1:0]        status,
  input logic              int_en,
  input logic              irq,
  input logic              reg_we,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [11:0]       attr0,
  input logic [ADDR_W-1:0] lo0,
  input logic [ADDR_W-1:0] info_addr
);
  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == 12'h0CC) && reg_wdata[0];

  assert_off_allows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |-> acc_allow);
  assert_nomatch_denied_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && !hit) |-> !acc_allow);
  assert_fault_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_allow) |=> (status != 2'b00));
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(acc_valid && !acc_allow)) |=> (status == 2'b00));
  assert_info_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status != 2'b00) && !clr_wr) |=> $stable(info_addr));
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);
  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 2'b00));
  assert_lock_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (attr0[11] && reg_we) |=> ($stable(lo0) && $stable(attr0)));
endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .func_en(func_en), .hit(hit),
  .acc_valid(acc_valid), .acc_allow(acc_allow), .status(status),
  .int_en(int_en), .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .attr0(attr_w[0]), .lo0(lo_w[0]), .info_addr(info_addr)
);

// File: tb/region_guard_bench.sv
module region_guard_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] VER = 32'h0240_1106;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0] acc_mode = 0;
  logic [4:0] acc_id = 0;
  logic [1:0] acc_type = 0;
  logic acc_allow, irq;
  int total = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  region_guard #(.VERSION(VER)) u_region_guard (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_mode(acc_mode), .acc_id(acc_id),
    .acc_type(acc_type), .acc_allow(acc_allow), .irq(irq));

  // {addr, mode, type, allow, status}
  localparam int NV = 13;
  localparam logic [38:0] VEC [NV] = '{
    {32'h0000_1000, 2'd0, 2'd0, 1'b1, 2'b00},
    {32'h0000_0FFF, 2'd0, 2'd0, 1'b0, 2'b10},
    {32'h0000_1FFF, 2'd0, 2'd1, 1'b1, 2'b00},
    {32'h0000_1FFF, 2'd1, 2'd1, 1'b0, 2'b01},
    {32'h0000_1800, 2'd0, 2'd2, 1'b1, 2'b00},
    {32'h0000_1800, 2'd0, 2'd1, 1'b1, 2'b00},
    {32'h0000_2000, 2'd0, 2'd1, 1'b0, 2'b01},
    {32'h0000_27FF, 2'd2, 2'd2, 1'b1, 2'b00},
    {32'h0000_2800, 2'd2, 2'd2, 1'b0, 2'b10},
    {32'h0000_1500, 2'd1, 2'd0, 1'b1, 2'b00},
    {32'h0000_1500, 2'd2, 2'd0, 1'b0, 2'b01},
    {32'h0000_1500, 2'd3, 2'd0, 1'b0, 2'b01},
    {32'h0000_1500, 2'd0, 2'd3, 1'b0, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic acc(input string req, input logic [31:0] a, input logic [1:0] m,
                     input logic [1:0] t, input logic [4:0] id, input logic exp);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_mode = m; acc_type = t; acc_id = id; #1;
    chk(req, {31'd0, acc_allow}, {31'd0, exp});
    @(negedge clk); acc_valid = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 3); rst_n = 1;
    // R1 reset state
    rd("R1", 12'h000, 32'h1);
    rd("R1", 12'h004, 32'h0);
    rd("R1", 12'h008, 32'hFFFF_FFFF);
    rd("R1", 12'h00C, 32'h0);
    rd("R1", 12'h0C4, 32'h1);
    rd("R1", 12'h0C8, 32'h0);
    rd("R1", 12'h0D8, 32'h0);
    rd("R1", 12'h0DC, 32'h1);
    chk("R1", {31'd0, irq}, 32'h0);

    // R2 R3 setup: window0 0x1000..0x1FFF m0 rw, m1 r; window1 0x1800..0x27FF m0 x, m2 x
    wr(12'h000, 32'h3);
    wr(12'h004, 32'h1000); wr(12'h008, 32'h1FFF); wr(12'h00C, 32'h046);
    wr(12'h010, 32'h1800); wr(12'h014, 32'h27FF); wr(12'h018, 32'h101);
    rd("R2", 12'h014, 32'h27FF);
    for (int i = 0; i < NV; i++) begin
      acc("R3", VEC[i][38:7], VEC[i][6:5], VEC[i][4:3], 5'd1, VEC[i][2]);
      rd("R5", 12'h0C8, {30'd0, VEC[i][1:0]});
      wr(12'h0CC, 32'h1);
    end

    // R7 capture first fault only; R5 sticky accumulation
    acc("R7", 32'h2000, 2'd0, 2'd1, 5'd7, 1'b0);
    acc("R7", 32'h3000, 2'd1, 2'd0, 5'd3, 1'b0);
    rd("R5", 12'h0C8, 32'h3);
    rd("R7", 12'h0D0, 32'h001C_0002);
    rd("R7", 12'h0D4, 32'h2000);

    // R8 interrupt masking
    chk("R8", {31'd0, irq}, 32'h0);
    wr(12'h0D8, 32'h1);
    #1 chk("R8", {31'd0, irq}, 32'h1);
    wr(12'h0CC, 32'h1);
    #1 chk("R8", {31'd0, irq}, 32'h0);
    // R6 clear
    rd("R6", 12'h0C8, 32'h0);
    rd("R6", 12'h0CC, 32'h0);
    rd("R7", 12'h0D4, 32'h2000);
    // R7 space fault after clear captures zero bitmap
    acc("R7", 32'h3000, 2'd2, 2'd0, 5'd31, 1'b0);
    rd("R7", 12'h0D0, 32'h007E_0000);
    wr(12'h0CC, 32'h1);

    // R4 checking off
    wr(12'h0C4, 32'h0);
    acc("R4", 32'h3000, 2'd0, 2'd0, 5'd2, 1'b1);
    rd("R4", 12'h0C8, 32'h0);
    wr(12'h0C4, 32'h1);

    // R9 lock
    wr(12'h00C, 32'h846);
    wr(12'h004, 32'h5000);
    rd("R9", 12'h004, 32'h1000);
    wr(12'h00C, 32'h0);
    rd("R9", 12'h00C, 32'h846);
    acc("R9", 32'h1000, 2'd0, 2'd0, 5'd1, 1'b1);
    wr(12'h000, 32'h0);
    rd("R9", 12'h000, 32'h0);
    acc("R9", 32'h1000, 2'd0, 2'd0, 5'd1, 1'b0);
    wr(12'h0CC, 32'h1);

    // R10 reserved bits, version, unmapped
    wr(12'h024, 32'hFFFF_FFFF);
    rd("R10", 12'h024, 32'hF77);
    rd("R10", 12'h7FC, VER);
    rd("R10", 12'h100, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule